// File: doc/BRIEF.md
# Clock Source Select and Divider Unit

This block produces three clock-enable streams inside a single system clock domain: a master stream for the processor, a sub-main stream for peripherals and an auxiliary stream. Each oscillator is modelled as a one-cycle tick input: the digitally controlled oscillator, a high-frequency crystal, a low-frequency crystal and an internal very-low-power oscillator. For each stream the block picks a source, divides its ticks by 1, 2, 4 or 8, and emits a one-cycle enable pulse.

Software programs three control registers and a flag register through a simple write port. The processor status byte arrives as an input. Its CPU-off bit gates the master stream and its two clock-gating bits gate the sub-main stream. When the mode bits ask for it, the internal low-power oscillator stands in for the low-frequency crystal. A watchdog on the crystal latches an oscillator-fault flag when the crystal falls silent.

Top module: `clk_src_div`

## Requirements
- R1: After reset all enable outputs and the fault flag are 0. The master and sub-main streams both run from the controlled oscillator at divide-by-1, and the auxiliary stream runs from the low-frequency source at divide-by-1.
- R2: The master source is set by write address 1, bits 7:6: 00 and 01 select the controlled oscillator, 10 the high-frequency crystal, 11 the low-frequency source. The sub-main source is set by address 1, bit 3: 0 selects the controlled oscillator and 1 the low-frequency source.
- R3: The divider fields are address 1 bits 5:4 (master), address 1 bits 2:1 (sub-main) and address 0 bits 5:4 (auxiliary). Codes 0 to 3 mean divide by 1, 2, 4 and 8. A stream pulses for exactly one cycle, in the cycle after every Nth tick of its source.
- R4: A new source or divider takes effect only when the current count completes, on the Nth tick of the old source. Until then, ticks of the newly selected source are not counted.
- R5: The low-frequency source is the very-low-power oscillator when address 2 bits 5:4 are 10 or 11 and address 0 bit 6 is 0. Otherwise it is the low-frequency crystal.
- R6: While status bit 4 is 1, the master enable stays 0, but its divider keeps counting.
- R7: While status bit 7 is 1, the sub-main enable stays 0. Status bit 6 also holds it at 0 while address 1 bit 3 is 0.
- R8: While the crystal is the low-frequency source, a fault condition arises when FAULT_TIMEOUT system clocks pass without a crystal tick. The condition sets the flag output, which is bit 1 of address 3, in the next cycle. Writing 0 to that bit clears the flag only once the condition has ended. A crystal tick or a switch to the internal oscillator ends the condition.
- R9: The auxiliary stream always runs from the low-frequency source, whatever the master and sub-main selections are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dco_tick_i | input | 1 | Controlled oscillator tick |
| hf_tick_i | input | 1 | High-frequency crystal tick |
| lfx_tick_i | input | 1 | Low-frequency crystal tick |
| vlo_tick_i | input | 1 | Very-low-power oscillator tick |
| sr_i | input | 8 | Processor status byte |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 control 1, 1 control 2, 2 control 3, 3 flag register |
| wr_data_i | input | 8 | Write data |
| mclk_en_o | output | 1 | Master clock enable pulse |
| smclk_en_o | output | 1 | Sub-main clock enable pulse |
| aclk_en_o | output | 1 | Auxiliary clock enable pulse |
| osc_fault_o | output | 1 | Latched oscillator-fault flag |

## Verification
The bench changes a divider in the middle of a count and switches the master stream onto a silent source, then revives it. A design that applied changes at once would emit a runt or early pulse, and one that counted the new source too soon would pulse while the old count was still open. Gating is exercised with every status bit and with the sub-main source both ways; a design that stopped the counter instead of masking the output would lose phase once gating was released. The fault flag is cleared while the crystal is still silent and again after the crystal ticks. A flag that cleared on any write, or never re-armed, would diverge from the model. The substitution mode bits are toggled while only one low-frequency source ticks, which exposes a wrong source choice on the auxiliary stream.

// File: rtl/clk_src_div_pkg.sv
package clk_src_div_pkg;

    localparam int DIV_CODE_W = 2;
    localparam int SRC_SEL_W  = 2;
    localparam int NUM_SRC    = 1 << SRC_SEL_W;
    localparam int CNT_W      = (1 << DIV_CODE_W) - 1;
    localparam int NUM_CHAN   = 3;

    typedef enum logic [SRC_SEL_W-1:0] {
        SRC_DCO_A = 2'd0,
        SRC_DCO_B = 2'd1,
        SRC_HF    = 2'd2,
        SRC_LF    = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        ADDR_CTL1 = 2'd0,
        ADDR_CTL2 = 2'd1,
        ADDR_CTL3 = 2'd2,
        ADDR_FLAG = 2'd3
    } reg_addr_e;

    function automatic logic [CNT_W-1:0] div_last(input logic [DIV_CODE_W-1:0] code);
        logic [CNT_W:0] one;
        one = (CNT_W+1)'(1);
        return CNT_W'((one << code) - one);
    endfunction

endpackage

// File: rtl/clk_div_chan.sv
module clk_div_chan
    import clk_src_div_pkg::*;
#(
    parameter logic [SRC_SEL_W-1:0] RST_SRC = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_ticks,
    input  logic [SRC_SEL_W-1:0]  req_src,
    input  logic [DIV_CODE_W-1:0] req_div,
    input  logic                  gate,
    output logic                  en_o
);

    typedef struct packed {
        logic [SRC_SEL_W-1:0]  src;
        logic [DIV_CODE_W-1:0] div;
        logic [CNT_W-1:0]      cnt;
        logic                  en;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     tick;

    always_comb begin
        st_d    = st_q;
        st_d.en = 1'b0;
        tick    = src_ticks[st_q.src];
        if (tick) begin
            if (st_q.cnt == div_last(st_q.div)) begin
                st_d.cnt = '0;
                st_d.src = req_src;
                st_d.div = req_div;
                st_d.en  = ~gate;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.src <= RST_SRC;
            st_q.div <= '0;
            st_q.cnt <= '0;
            st_q.en  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;

endmodule

// File: rtl/osc_fault_mon.sv
module osc_fault_mon #(
    parameter int TIMEOUT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_tick,
    input  logic watch,
    input  logic clr_we,
    input  logic clr_val,
    output logic flag_o
);

    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } mon_st_t;

    mon_st_t st_d, st_q;
    logic    fault_cond;

    always_comb begin
        st_d       = st_q;
        fault_cond = (st_q.cnt == LIMIT);
        if (!watch || xtal_tick) begin
            st_d.cnt = '0;
        end else if (!fault_cond) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
        if (fault_cond) begin
            st_d.flag = 1'b1;
        end else if (clr_we) begin
            st_d.flag = clr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/clk_src_div.sv
module clk_src_div
    import clk_src_div_pkg::*;
#(
    parameter int FAULT_TIMEOUT = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dco_tick_i,
    input  logic       hf_tick_i,
    input  logic       lfx_tick_i,
    input  logic       vlo_tick_i,
    input  logic [7:0] sr_i,
    input  logic       wr_en_i,
    input  logic [1:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    output logic       mclk_en_o,
    output logic       smclk_en_o,
    output logic       aclk_en_o,
    output logic       osc_fault_o
);

    localparam int CH_M = 0;
    localparam int CH_S = 1;
    localparam int CH_A = 2;

    typedef struct packed {
        logic                  xts;
        logic [DIV_CODE_W-1:0] diva;
        logic [SRC_SEL_W-1:0]  selm;
        logic [DIV_CODE_W-1:0] divm;
        logic                  sels;
        logic [DIV_CODE_W-1:0] divs;
        logic [1:0]            lfsel;
    } cfg_t;

    cfg_t      cfg_d, cfg_q;
    reg_addr_e waddr;
    logic      subst;
    logic      lf_tick;
    logic      flag_we;

    logic [NUM_SRC-1:0]    srcs;
    logic [SRC_SEL_W-1:0]  req_src [NUM_CHAN];
    logic [DIV_CODE_W-1:0] req_div [NUM_CHAN];
    logic [NUM_CHAN-1:0]   gate;
    logic [NUM_CHAN-1:0]   en_vec;
    logic                  unused_bits;

    assign waddr       = reg_addr_e'(wr_addr_i);
    assign unused_bits = ^{wr_data_i[0], sr_i[5], sr_i[3:0]};

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            unique case (waddr)
                ADDR_CTL1: begin
                    cfg_d.xts  = wr_data_i[6];
                    cfg_d.diva = wr_data_i[5:4];
                end
                ADDR_CTL2: begin
                    cfg_d.selm = wr_data_i[7:6];
                    cfg_d.divm = wr_data_i[5:4];
                    cfg_d.sels = wr_data_i[3];
                    cfg_d.divs = wr_data_i[2:1];
                end
                ADDR_CTL3: cfg_d.lfsel = wr_data_i[5:4];
                ADDR_FLAG: ;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign subst   = cfg_q.lfsel[1] & ~cfg_q.xts;
    assign lf_tick = subst ? vlo_tick_i : lfx_tick_i;

    assign srcs[SRC_DCO_A] = dco_tick_i;
    assign srcs[SRC_DCO_B] = dco_tick_i;
    assign srcs[SRC_HF]    = hf_tick_i;
    assign srcs[SRC_LF]    = lf_tick;

    always_comb begin
        req_src[CH_M] = cfg_q.selm;
        req_div[CH_M] = cfg_q.divm;
        gate[CH_M]    = sr_i[4];
        req_src[CH_S] = cfg_q.sels ? SRC_LF : SRC_DCO_A;
        req_div[CH_S] = cfg_q.divs;
        gate[CH_S]    = sr_i[7] | (sr_i[6] & ~cfg_q.sels);
        req_src[CH_A] = SRC_LF;
        req_div[CH_A] = cfg_q.diva;
        gate[CH_A]    = 1'b0;
    end

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
        clk_div_chan #(
            .RST_SRC((g == CH_A) ? SRC_LF : SRC_DCO_A)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_ticks (srcs),
            .req_src   (req_src[g]),
            .req_div   (req_div[g]),
            .gate      (gate[g]),
            .en_o      (en_vec[g])
        );
    end

    assign flag_we = wr_en_i & (waddr == ADDR_FLAG);

    osc_fault_mon #(
        .TIMEOUT (FAULT_TIMEOUT)
    ) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtal_tick (lfx_tick_i),
        .watch     (~subst),
        .clr_we    (flag_we),
        .clr_val   (wr_data_i[1]),
        .flag_o    (osc_fault_o)
    );

    assign mclk_en_o  = en_vec[CH_M];
    assign smclk_en_o = en_vec[CH_S];
    assign aclk_en_o  = en_vec[CH_A];

endmodule

// File: rtl/clk_src_div_chk.sv
module clk_src_div_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dco_tick_i,
    input logic       hf_tick_i,
    input logic       lfx_tick_i,
    input logic       vlo_tick_i,
    input logic [7:0] sr_i,
    input logic       wr_en_i,
    input logic [1:0] wr_addr_i,
    input logic [7:0] wr_data_i,
    input logic       mclk_en_o,
    input logic       smclk_en_o,
    input logic       aclk_en_o,
    input logic       osc_fault_o
);

    // R6
    mclk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_i[4] |=> !mclk_en_o);

    // R7
    smclk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_i[7] |=> !smclk_en_o);

    // R2
    mclk_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_en_o |-> $past(dco_tick_i | hf_tick_i | lfx_tick_i | vlo_tick_i));

    // R9
    aclk_lf_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aclk_en_o |-> $past(lfx_tick_i | vlo_tick_i));

    // R3
    mclk_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mclk_en_o && !$past(dco_tick_i | hf_tick_i | lfx_tick_i | vlo_tick_i, 1)) |-> 1'b0);

    // R8
    flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_fault_o) |-> $past(wr_en_i && (wr_addr_i == 2'd3) && !wr_data_i[1]));

endmodule

bind clk_src_div clk_src_div_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dco_tick_i  (dco_tick_i),
    .hf_tick_i   (hf_tick_i),
    .lfx_tick_i  (lfx_tick_i),
    .vlo_tick_i  (vlo_tick_i),
    .sr_i        (sr_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .mclk_en_o   (mclk_en_o),
    .smclk_en_o  (smclk_en_o),
    .aclk_en_o   (aclk_en_o),
    .osc_fault_o (osc_fault_o)
);

// File: tb/sim_clk_src_div.sv
`timescale 1ns/1ps
module sim_clk_src_div;

    localparam int TO = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dco = 1'b0, hf = 1'b0, lfx = 1'b0, vlo = 1'b0;
    logic [7:0] sr = 8'h00;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       mclk_en, smclk_en, aclk_en, osc_fault;

    clk_src_div #(.FAULT_TIMEOUT(TO)) u0 (
        .clk(clk), .rst_n(rst_n),
        .dco_tick_i(dco), .hf_tick_i(hf), .lfx_tick_i(lfx), .vlo_tick_i(vlo),
        .sr_i(sr), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .mclk_en_o(mclk_en), .smclk_en_o(smclk_en), .aclk_en_o(aclk_en),
        .osc_fault_o(osc_fault)
    );

    always #5 clk = ~clk;

    int    n_cmp = 0, n_bad = 0, cyc = 0;
    string tag = "R1";
    int    p_dco = 0, p_hf = 0, p_lfx = 0, p_vlo = 0;
    bit    pend_we = 0;
    logic [1:0] pend_a = 0;
    logic [7:0] pend_d = 0;
    bit    done = 0;

    // Behavioural reference state
    int m_src [3];
    int m_div [3];
    int m_cnt [3];
    int ctl1 = 0, ctl2 = 0, ctl3 = 0;
    int fcnt = 0;
    bit flag = 0;
    bit exp_en [3];

    function automatic bit src_tick(int s, bit lf);
        if (s == 2) return hf;
        if (s == 3) return lf;
        return dco;
    endfunction

    always @(posedge clk) begin
        int  rq_s [3];
        int  rq_d [3];
        bit  gt [3];
        bit  sub, lf, t, fc;
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_src[i] = (i == 2) ? 3 : 0; m_div[i] = 0; m_cnt[i] = 0; exp_en[i] = 0;
            end
            ctl1 = 0; ctl2 = 0; ctl3 = 0; fcnt = 0; flag = 0;
        end else begin
            sub = (((ctl3 >> 4) & 3) >= 2) && (((ctl1 >> 6) & 1) == 0);
            lf  = sub ? vlo : lfx;
            rq_s[0] = (ctl2 >> 6) & 3;          rq_d[0] = (ctl2 >> 4) & 3; gt[0] = sr[4];
            rq_s[1] = ((ctl2 >> 3) & 1) ? 3 : 0; rq_d[1] = (ctl2 >> 1) & 3;
            gt[1] = sr[7] || (sr[6] && !((ctl2 >> 3) & 1));
            rq_s[2] = 3;                         rq_d[2] = (ctl1 >> 4) & 3; gt[2] = 0;
            for (int i = 0; i < 3; i++) begin
                exp_en[i] = 0;
                t = src_tick(m_src[i], lf);
                if (t) begin
                    if (m_cnt[i] + 1 == (1 << m_div[i])) begin
                        m_cnt[i] = 0; m_src[i] = rq_s[i]; m_div[i] = rq_d[i];
                        exp_en[i] = !gt[i];
                    end else m_cnt[i]++;
                end
            end
            fc = (fcnt >= TO);
            if (fc) flag = 1;
            else if (wr_en && wr_addr == 3) flag = wr_data[1];
            if (sub || lfx) fcnt = 0;
            else if (!fc) fcnt++;
            if (wr_en) begin
                if (wr_addr == 0) ctl1 = wr_data;
                else if (wr_addr == 1) ctl2 = wr_data;
                else if (wr_addr == 2) ctl3 = wr_data;
            end
        end
    end

    task automatic check1(string what, bit act, bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cyc, act, exp);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        check1("mclk_en", mclk_en, exp_en[0]);
        check1("smclk_en", smclk_en, exp_en[1]);
        check1("aclk_en", aclk_en, exp_en[2]);
        check1("osc_fault", osc_fault, flag);
        dco = ($urandom_range(99) < p_dco);
        hf  = ($urandom_range(99) < p_hf);
        lfx = ($urandom_range(99) < p_lfx);
        vlo = ($urandom_range(99) < p_vlo);
        wr_en = pend_we; wr_addr = pend_a; wr_data = pend_d;
        pend_we = 0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        pend_we = 1; pend_a = a; pend_d = d;
        cycle();
    endtask

    task automatic probs(int d, int h, int l, int v);
        p_dco = d; p_hf = h; p_lfx = l; p_vlo = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state, then default DCO /1 on both main streams
        tag = "R1"; probs(50, 0, 30, 0);
        run(4);
        rst_n = 1'b1;
        run(60);
        // R2: master source selection, sub-main source selection
        tag = "R2"; probs(40, 40, 40, 0);
        wr(2'd1, 8'b1000_0000); run(80);
        wr(2'd1, 8'b1100_0000); run(80);
        wr(2'd1, 8'b0100_1000); run(80);
        // R3: divider codes on all three streams
        tag = "R3"; probs(60, 20, 50, 0);
        wr(2'd1, 8'b0001_0100); wr(2'd0, 8'b0011_0000); run(200);
        wr(2'd1, 8'b0011_0010); wr(2'd0, 8'b0001_0000); run(200);
        wr(2'd1, 8'b0010_0110); wr(2'd0, 8'b0010_0000); run(200);
        // R4: change mid-count, and switch onto a silent source then revive it
        tag = "R4"; probs(30, 0, 40, 0);
        wr(2'd1, 8'b0011_0000); run(3);
        wr(2'd1, 8'b0000_0000); run(40);
        wr(2'd1, 8'b1001_0000); run(60);
        probs(30, 35, 40, 0); run(80);
        wr(2'd1, 8'b0000_0000); run(40);
        // R5: substitution of the low-power oscillator
        tag = "R5"; probs(50, 0, 0, 40);
        wr(2'd1, 8'b1100_1000); wr(2'd2, 8'b0010_0000); run(120);
        wr(2'd2, 8'b0011_0000); run(80);
        probs(50, 0, 45, 0);
        wr(2'd0, 8'b0100_0000); run(80);
        wr(2'd0, 8'b0000_0000); wr(2'd2, 8'b0001_0000); run(80);
        wr(2'd3, 8'h00); run(10);
        // R6: CPU-off gating keeps the count running
        tag = "R6"; probs(60, 0, 50, 0);
        wr(2'd1, 8'b0001_0000);
        sr = 8'h10; run(37);
        sr = 8'h00; run(60);
        // R7: sub-main gating by both status bits
        tag = "R7";
        wr(2'd1, 8'b0000_0010);
        sr = 8'h80; run(50);
        sr = 8'h40; run(50);
        wr(2'd1, 8'b0000_1010); run(60);
        sr = 8'hC0; run(40);
        sr = 8'h00; run(40);
        // R8: fault detection, blocked clear, clear after recovery
        tag = "R8"; probs(50, 0, 0, 50);
        wr(2'd1, 8'b0000_0000); run(TO + 20);
        wr(2'd3, 8'h00); run(10);
        probs(50, 0, 60, 0); run(10);
        wr(2'd3, 8'h00); run(20);
        probs(50, 0, 0, 0); run(TO + 5);
        wr(2'd2, 8'b0010_0000); run(4);
        wr(2'd3, 8'h00); run(20);
        wr(2'd3, 8'h02); run(10);
        wr(2'd3, 8'h00); wr(2'd2, 8'h00); probs(50, 0, 50, 0); run(20);
        // R9: auxiliary stream ignores master and sub-main selections
        tag = "R9"; probs(50, 50, 40, 40);
        wr(2'd0, 8'b0001_0000);
        wr(2'd1, 8'hFF); run(100);
        wr(2'd1, 8'h00); run(100);
        finish_run();
    end

endmodule